// File: doc/BRIEF.md
# Byte-Lane Coded Result Output Port

This block hands a 16-bit conversion result to an 8-bit host bus. A transfer strobe copies the result and its range flag into a holding register. The host reads that register one byte at a time. Each byte lane has its own active-low enable. Any number of reads between two strobes return the same word.

Each lane leaves the block as a data vector plus an output-enable, which is the usual form for a pad cell. A lane whose enable is inactive drops its output-enable and drives zeros on its data. The high lane also carries a complemented copy of the most significant bit. A host can therefore take two's-complement code by wiring that line in place of the true MSB. A format input gives the same choice inside the block, by putting the complemented bit on lane bit 7 itself. The range flag leaves the block active low.

Top module: `codedByteOutPort`

## Requirements
- R1: While `rstN` is low, and after reset until the first strobe, the held word is 0x0000 and `rangeOutN` is 1.
- R2: A high `xferStb` at a rising clock edge loads `resultIn` and `rangeHitIn` into the holding register. With `xferStb` low, changes on `resultIn` and `rangeHitIn` have no effect on any output.
- R3: While `hiEnN` is 0, `hiOe` is 1 and `hiData[6:0]` equals held word bits 14..8. `msbBarOut` equals the inverse of held word bit 15.
- R4: While `loEnN` is 0, `loOe` is 1 and `loData` equals held word bits 7..0.
- R5: While `hiEnN` is 1, `hiOe` is 0 and both `hiData` and `msbBarOut` are 0. While `loEnN` is 1, `loOe` is 0 and `loData` is 0.
- R6: With `fmtSel` = 0, `hiData[7]` is held word bit 15 (offset binary). With `fmtSel` = 1, `hiData[7]` is its inverse (two's complement). No other lane bit depends on `fmtSel`.
- R7: `rangeOutN` is 0 exactly when the held range flag was captured as 1, meaning full scale was exceeded. It is driven whatever the state of the lane enables.
- R8: A mid-scale word of 0x8000 reads as high byte 0x80 when `fmtSel` = 0, and as 0x00 when `fmtSel` = 1.
- R9: The two lanes are independent. Enabling or disabling one lane does not change the other lane's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| resultIn | input | 16 | Conversion result |
| rangeHitIn | input | 1 | High when the result exceeded full scale |
| xferStb | input | 1 | Transfer strobe that loads the holding register |
| hiEnN | input | 1 | High-lane enable, active low |
| loEnN | input | 1 | Low-lane enable, active low |
| fmtSel | input | 1 | Lane bit 7 coding: 0 true MSB, 1 complemented MSB |
| hiData | output | 8 | High-lane data |
| hiOe | output | 1 | High-lane output-enable |
| msbBarOut | output | 1 | Complemented MSB, gated with the high lane |
| loData | output | 8 | Low-lane data |
| loOe | output | 1 | Low-lane output-enable |
| rangeOutN | output | 1 | Range flag, active low |

## Verification
The assertions assume `xferStb` is a synchronous single-bit strobe. They also assume `resultIn` and `rangeHitIn` are settled at any edge where the strobe is high. Both are sampled only on that edge, so nothing is said about them between strobes. The bench changes every input shortly after a rising edge, well clear of the next one. Between strobes it deliberately changes the result, the flag and the lane enables, to show that only the strobe moves the held word.

// File: rtl/codedPortPkg.sv
package codedPortPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic driveHi;
    logic driveLo;
    logic flipMsb;
  } laneStrobes_t;
endpackage

// File: rtl/laneCtrl.sv
module laneCtrl
  import codedPortPkg::*;
(
  input  logic         xferStb,
  input  logic         hiEnN,
  input  logic         loEnN,
  input  logic         fmtSel,
  output laneStrobes_t strobes
);
  always_comb begin
    strobes.loadWord = xferStb;
    strobes.driveHi  = ~hiEnN;
    strobes.driveLo  = ~loEnN;
    strobes.flipMsb  = fmtSel;
  end
endmodule

// File: rtl/laneData.sv
module laneData
  import codedPortPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strobes,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              rangeHitIn,
  output logic [LANE_W-1:0] hiData,
  output logic              hiOe,
  output logic              msbBarOut,
  output logic [LANE_W-1:0] loData,
  output logic              loOe,
  output logic              rangeOutN
);
  localparam int MSB_POS = WORD_W - 1;
  localparam int HI_LSB  = WORD_W - LANE_W;

  logic [WORD_W-1:0] wordQ;
  logic              rangeHitQ;
  logic [LANE_W-1:0] hiRaw;

  // Holding register: loads only on the transfer strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ     <= '0;
      rangeHitQ <= 1'b0;
    end else if (strobes.loadWord) begin
      wordQ     <= resultIn;
      rangeHitQ <= rangeHitIn;
    end
  end

  // High lane: top bit optionally complemented
  generate
    if (LANE_W > 1) begin : g_wideLane
      always_comb hiRaw = {wordQ[MSB_POS] ^ strobes.flipMsb, wordQ[MSB_POS-1:HI_LSB]};
    end else begin : g_bitLane
      always_comb hiRaw = wordQ[MSB_POS] ^ strobes.flipMsb;
    end
  endgenerate

  always_comb begin
    hiOe      = strobes.driveHi;
    hiData    = strobes.driveHi ? hiRaw : '0;
    msbBarOut = strobes.driveHi & ~wordQ[MSB_POS];
    loOe      = strobes.driveLo;
    loData    = strobes.driveLo ? wordQ[LANE_W-1:0] : '0;
    rangeOutN = ~rangeHitQ;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.loadWord |=> $stable(wordQ) && $stable(rangeOutN));
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord |=> wordQ == $past(resultIn));
  p_quiet_hi_r5: assert property (@(posedge clk) disable iff (!rstN)
    !hiOe |-> (hiData == '0) && !msbBarOut);
  p_quiet_lo_r5: assert property (@(posedge clk) disable iff (!rstN)
    !loOe |-> loData == '0);
  p_bar_r3: assert property (@(posedge clk) disable iff (!rstN)
    hiOe && !strobes.flipMsb |-> msbBarOut != hiData[LANE_W-1]);
  p_flag_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadWord |=> rangeOutN == !$past(rangeHitIn));
endmodule

// File: rtl/codedByteOutPort.sv
module codedByteOutPort
  import codedPortPkg::*;
#(
  parameter int WORD_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] resultIn,
  input  logic              rangeHitIn,
  input  logic              xferStb,
  input  logic              hiEnN,
  input  logic              loEnN,
  input  logic              fmtSel,
  output logic [LANE_W-1:0] hiData,
  output logic              hiOe,
  output logic              msbBarOut,
  output logic [LANE_W-1:0] loData,
  output logic              loOe,
  output logic              rangeOutN
);
  laneStrobes_t strobes;

  laneCtrl i_ctrl (
    .xferStb (xferStb),
    .hiEnN   (hiEnN),
    .loEnN   (loEnN),
    .fmtSel  (fmtSel),
    .strobes (strobes)
  );

  laneData #(.WORD_W(WORD_W), .LANE_W(LANE_W)) i_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .resultIn   (resultIn),
    .rangeHitIn (rangeHitIn),
    .hiData     (hiData),
    .hiOe       (hiOe),
    .msbBarOut  (msbBarOut),
    .loData     (loData),
    .loOe       (loOe),
    .rangeOutN  (rangeOutN)
  );
endmodule

// File: tb/test_codedByteOutPort.sv
module test_codedByteOutPort;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] resultIn = '0;
  logic rangeHitIn = 1'b0, xferStb = 1'b0, hiEnN = 1'b1, loEnN = 1'b1, fmtSel = 1'b0;
  logic [7:0] hiData, loData;
  logic hiOe, msbBarOut, loOe, rangeOutN;

  int total = 0;
  int bad = 0;

  typedef struct packed {
    logic [7:0] hi; logic hiOe; logic bar; logic [7:0] lo; logic loOe; logic rn;
  } obs_t;

  obs_t  expQ[$];
  string tagQ[$];
  logic [15:0] mdlWord = '0;
  logic        mdlHit  = 1'b0;

  always #5 clk = ~clk;

  codedByteOutPort i_codedByteOutPort (
    .clk(clk), .rstN(rstN), .resultIn(resultIn), .rangeHitIn(rangeHitIn),
    .xferStb(xferStb), .hiEnN(hiEnN), .loEnN(loEnN), .fmtSel(fmtSel),
    .hiData(hiData), .hiOe(hiOe), .msbBarOut(msbBarOut),
    .loData(loData), .loOe(loOe), .rangeOutN(rangeOutN)
  );

  function automatic obs_t predict(logic [15:0] w, logic hit, logic hEn, logic lEn, logic f);
    obs_t o;
    o.hiOe = hEn;
    o.hi   = hEn ? {w[15] ^ f, w[14:8]} : 8'h00;
    o.bar  = hEn ? ~w[15] : 1'b0;
    o.loOe = lEn;
    o.lo   = lEn ? w[7:0] : 8'h00;
    o.rn   = ~hit;
    return o;
  endfunction

  function automatic obs_t sample();
    return {hiData, hiOe, msbBarOut, loData, loOe, rangeOutN};
  endfunction

  // Driver: inputs change 2 ns after a rising edge; expectation uses the word held now
  task automatic step(string tag, logic [15:0] res, logic hit, logic stb,
                      logic hEnN, logic lEnN, logic f);
    @(posedge clk);
    #2;
    resultIn = res; rangeHitIn = hit; xferStb = stb;
    hiEnN = hEnN; loEnN = lEnN; fmtSel = f;
    expQ.push_back(predict(mdlWord, mdlHit, ~hEnN, ~lEnN, f));
    tagQ.push_back(tag);
    if (stb) begin
      mdlWord = res;
      mdlHit  = hit;
    end
  endtask

  // Monitor: compares at the falling edge
  always @(negedge clk) begin
    if (rstN && expQ.size() > 0) begin
      obs_t e;
      obs_t a;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      a = sample();
      total++;
      if (a !== e) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    // R1: reset values seen with both lanes enabled
    hiEnN = 1'b0;
    loEnN = 1'b0;
    #23;
    total++;
    if (sample() !== predict(16'h0000, 1'b0, 1'b1, 1'b1, 1'b0)) begin
      bad++;
      $display("FAIL R1 actual=%h expected=%h", sample(), predict(16'h0000, 1'b0, 1'b1, 1'b1, 1'b0));
    end
    @(posedge clk);
    #2;
    rstN = 1'b1;
    step("R1", 16'h1234, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R2", 16'hA5C3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    step("R3", 16'h0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R4", 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R2", 16'h5555, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5", 16'h5555, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    step("R6", 16'h8000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R8", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R8", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7", 16'hFFFF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R7", 16'h0001, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    step("R9", 16'h0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R9", 16'h0001, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    step("R6", 16'h7FFE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
    step("R6", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R3", 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R5", 16'h0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    @(posedge clk);
    @(negedge clk);
    #1;
    finishRun();
  end
endmodule